// File: doc/BRIEF.md
# SPI flash command engine with shared buffer

This block is a memory-mapped SPI master that runs one half-duplex flash transaction at a time. Software fills a 128-byte shared buffer from byte 0 upward with the whole outgoing stream: opcode, address, dummy bytes and any write data. It then sets an output byte count and an input byte count and fires a trigger. The engine lowers chip select and shifts out the output bytes. It then keeps clocking for the requested number of input bytes and stores each received byte in the same buffer, directly after the last output byte. Finally it raises chip select and keeps the transaction open for a programmable number of deselect cycles.

The serial clock has no divider. Each bit takes two interface clock cycles: one with SCLK low and one with SCLK high. The lines run in SPI mode 0 with single-bit data. Progress is reported with a two-flag handshake. A ready flag rises as soon as a trigger is accepted, and a busy flag falls once the transaction, including the deselect time, has finished. A soft-reset bit aborts any transaction in flight.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sclk is 0, and the control (0x500), length (0x504, 0x508), miscellaneous (0x538) and status (0x550) registers read 0.
- R2: The buffer at 0x800..0x87F is accessed as 32-bit words, with buffer byte 4w+n held in bits 8n+7:8n of word w. The output length (0x504) and input length (0x508) registers read back the low 8 bits written to them.
- R3: A control write with bit 3 (enable) and bit 2 (trigger) both set is a trigger. When busy is clear and the lengths are valid, the trigger sets busy (bit 0) and ready (bit 1) from the next cycle, and spi_cs_n falls on that same clock edge. Ready stays set while busy is set.
- R4: Bytes 0 to outlen-1 of the buffer are sent MSB first in SPI mode 0. SCLK idles low and alternates one cycle low, one cycle high, starting low. MOSI changes only when SCLK falls.
- R5: After the output bytes the engine clocks inlen more bytes with MOSI at 0. It samples MISO on each rising SCLK and writes input byte k to buffer offset outlen+k. All other buffer bytes are left unchanged.
- R6: spi_cs_n stays low without a gap for all 16*(outlen+inlen) cycles of a transaction and rises together with the final SCLK fall. Busy then clears exactly N+1 cycles after spi_cs_n rises, where N is misc bits 4:0.
- R7: A trigger with outlen 0, or with outlen+inlen above 128, sets ready, leaves busy clear, never lowers spi_cs_n and leaves the buffer unchanged.
- R8: A trigger written while busy is set is ignored. The running transaction continues unchanged.
- R9: A control write with bit 3 clear, made while busy is clear, clears ready. Control bits 3 and 4 read back as written, and bit 2 always reads 0.
- R10: Status bits 3:0 read 0 when idle, 1 during output bytes, 2 during input bytes and 3 during the deselect time.
- R11: Misc bits 4:0, 9:8 and 26:25 read back as written. Writing misc bit 28 aborts any transaction: from the next cycle spi_cs_n is 1, spi_sclk is 0, control reads 0 and status reads 0. Bit 28 always reads 0.
- R12: Bus writes to the buffer are ignored while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, also the source of SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 12 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A behavioural model predicts chip select, SCLK and MOSI on every cycle and the buffer image after each transaction. The tests cover five cases:
- A command with a short read, which separates the output phase from the input phase and checks where received bytes land.
- A write-only command, which shows the input phase is skipped entirely.
- A one-byte command followed by 127 input bytes, which exercises the exact 128-byte limit.
- Zero-length and oversize triggers, which must leave the pins idle.
- A retrigger and a buffer write while busy, and a soft reset mid-transfer, which separate ignored stimuli from accepted ones.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam logic [11:0] OFS_CTRL = 12'h500;
  localparam logic [11:0] OFS_OUTL = 12'h504;
  localparam logic [11:0] OFS_INL  = 12'h508;
  localparam logic [11:0] OFS_MISC = 12'h538;
  localparam logic [11:0] OFS_STAT = 12'h550;
  localparam logic [11:0] OFS_BUF  = 12'h800;

  localparam int CB_BUSY  = 0;
  localparam int CB_READY = 1;
  localparam int CB_TRIG  = 2;
  localparam int CB_EN    = 3;
  localparam int CB_MIO   = 4;
  localparam int MB_SRST  = 28;

  typedef enum logic [1:0] {SQ_IDLE, SQ_XFER, SQ_DESEL} seq_e;

  // a transaction is run only when it sends something and fits the buffer
  function automatic logic len_ok(int unsigned o, int unsigned i, int unsigned cap);
    return (o != 0) && (o + i <= cap);
  endfunction

  function automatic logic [3:0] stat_code(seq_e s, logic in_ph);
    case (s)
      SQ_XFER:  return in_ph ? 4'd2 : 4'd1;
      SQ_DESEL: return 4'd3;
      default:  return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_buf.sv
module spi_eng_buf #(
  parameter int BUF_BYTES = 128,
  localparam int AW  = $clog2(BUF_BYTES),
  localparam int WAW = AW - 2
) (
  input  logic           clk,
  input  logic           bus_we,
  input  logic [WAW-1:0] bus_widx,
  input  logic [31:0]    bus_wdata,
  input  logic [WAW-1:0] bus_ridx,
  output logic [31:0]    bus_rdata,
  input  logic           eng_we,
  input  logic [AW-1:0]  eng_widx,
  input  logic [7:0]     eng_wdata,
  input  logic [AW-1:0]  eng_ridx,
  output logic [7:0]     eng_rdata
);
  logic [7:0] bytes_w [BUF_BYTES];

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_byte
    localparam logic [AW-1:0] BI = AW'(g);
    logic [7:0] byte_q;
    // the engine port wins a same-cycle collision (bus writes are blocked while busy anyway)
    always_ff @(posedge clk) begin
      if (eng_we && eng_widx == BI) byte_q <= eng_wdata;
      else if (bus_we && bus_widx == BI[AW-1:2]) byte_q <= bus_wdata[8*(g%4) +: 8];
    end
    assign bytes_w[g] = byte_q;
  end

  always_comb begin
    for (int b = 0; b < 4; b++) bus_rdata[8*b +: 8] = bytes_w[{bus_ridx, 2'(b)}];
  end
  assign eng_rdata = bytes_w[eng_ridx];
endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq import spi_eng_pkg::*; #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int DESEL_W   = 5,
  localparam int AW    = $clog2(BUF_BYTES),
  localparam int IDX_W = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               start,
  input  logic [LEN_W-1:0]   out_len,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [DESEL_W-1:0] desel_cyc,
  output logic [AW-1:0]      buf_ridx,
  input  logic [7:0]         buf_rdata,
  output logic               buf_we,
  output logic [AW-1:0]      buf_widx,
  output logic [7:0]         buf_wdata,
  output logic               busy,
  output logic [3:0]         stat,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  seq_e               st;
  logic [IDX_W-1:0]   idx, lat_out, lat_tot;
  logic [2:0]         bitcnt;
  logic [7:0]         tx, rx;
  logic [DESEL_W-1:0] cnt;

  // named events used by the datapath and the assertions
  logic [IDX_W-1:0] next_idx;
  logic in_phase, byte_done, last_byte, next_is_out;
  assign next_idx    = idx + IDX_W'(1);
  assign in_phase    = idx >= lat_out;
  assign byte_done   = (st == SQ_XFER) && sclk && (bitcnt == 3'd7);
  assign last_byte   = next_idx == lat_tot;
  assign next_is_out = next_idx < lat_out;

  assign buf_ridx  = (st == SQ_IDLE) ? '0 : next_idx[AW-1:0];
  assign buf_we    = byte_done && in_phase;
  assign buf_widx  = idx[AW-1:0];
  assign buf_wdata = rx;
  assign busy      = st != SQ_IDLE;
  assign stat      = stat_code(st, in_phase);
  assign mosi      = tx[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_IDLE; cs_n <= 1'b1; sclk <= 1'b0; tx <= '0; rx <= '0;
      bitcnt <= '0; idx <= '0; cnt <= '0; lat_out <= '0; lat_tot <= '0;
    end else if (soft_rst) begin
      st <= SQ_IDLE; cs_n <= 1'b1; sclk <= 1'b0; tx <= '0; rx <= '0;
      bitcnt <= '0; idx <= '0; cnt <= '0; lat_out <= '0; lat_tot <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st      <= SQ_XFER;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          bitcnt  <= '0;
          idx     <= '0;
          tx      <= buf_rdata;
          lat_out <= IDX_W'(out_len);
          lat_tot <= IDX_W'(out_len) + IDX_W'(in_len);
        end
        SQ_XFER: if (!sclk) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitcnt == 3'd7) begin
            bitcnt <= '0;
            if (last_byte) begin
              st   <= SQ_DESEL;
              cs_n <= 1'b1;
              cnt  <= desel_cyc;
            end else begin
              idx <= next_idx;
              tx  <= next_is_out ? buf_rdata : 8'h00;
            end
          end else begin
            bitcnt <= bitcnt + 3'd1;
            tx     <= {tx[6:0], 1'b0};
          end
        end
        SQ_DESEL: if (cnt == '0) st <= SQ_IDLE; else cnt <= cnt - DESEL_W'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!cs_n && sclk) |-> $stable(mosi)); // R4
  AST_CS_UP_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> cs_n); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (st == SQ_XFER) |-> (idx < lat_tot)); // R5
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R8
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine import spi_eng_pkg::*; #(
  parameter int BUF_BYTES = 128,
  parameter int LEN_W     = 8,
  parameter int DESEL_W   = 5,
  localparam int AW  = $clog2(BUF_BYTES),
  localparam int WAW = AW - 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wen,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic               ctrl_en, ctrl_mio, ready;
  logic [LEN_W-1:0]   out_len_q, in_len_q;
  logic [DESEL_W-1:0] desel_q;
  logic [1:0]         latch_q, fifo_q;

  logic eng_busy;
  logic [3:0] eng_stat;
  logic [31:0] buf_word;
  logic [AW-1:0] eb_ridx, eb_widx;
  logic [7:0] eb_rdata, eb_wdata;
  logic eb_we;

  logic buf_hit, ctrl_wr, trig_req, trig_acc, lens_valid, eng_start, soft_rst, buf_wr;
  assign buf_hit    = (reg_addr >= OFS_BUF) && (reg_addr < OFS_BUF + 12'(BUF_BYTES));
  assign ctrl_wr    = reg_wen && (reg_addr == OFS_CTRL);
  assign trig_req   = ctrl_wr && reg_wdata[CB_TRIG] && reg_wdata[CB_EN];
  assign trig_acc   = trig_req && !eng_busy;
  assign lens_valid = len_ok(int'(out_len_q), int'(in_len_q), BUF_BYTES);
  assign eng_start  = trig_acc && lens_valid;
  assign soft_rst   = reg_wen && (reg_addr == OFS_MISC) && reg_wdata[MB_SRST];
  assign buf_wr     = reg_wen && buf_hit && !eng_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0; ctrl_mio <= 1'b0; ready <= 1'b0;
      out_len_q <= '0; in_len_q <= '0; desel_q <= '0; latch_q <= '0; fifo_q <= '0;
    end else begin
      if (reg_wen && reg_addr == OFS_OUTL) out_len_q <= reg_wdata[LEN_W-1:0];
      if (reg_wen && reg_addr == OFS_INL)  in_len_q  <= reg_wdata[LEN_W-1:0];
      if (reg_wen && reg_addr == OFS_MISC) begin
        desel_q <= reg_wdata[DESEL_W-1:0];
        latch_q <= reg_wdata[9:8];
        fifo_q  <= reg_wdata[26:25];
      end
      if (soft_rst) begin
        ctrl_en <= 1'b0; ctrl_mio <= 1'b0; ready <= 1'b0;
      end else begin
        if (ctrl_wr) begin
          ctrl_en  <= reg_wdata[CB_EN];
          ctrl_mio <= reg_wdata[CB_MIO];
        end
        if (trig_acc) ready <= 1'b1;
        else if (ctrl_wr && !reg_wdata[CB_EN] && !eng_busy) ready <= 1'b0;
      end
    end
  end

  spi_eng_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .bus_we(buf_wr), .bus_widx(reg_addr[AW-1:2]), .bus_wdata(reg_wdata),
    .bus_ridx(reg_addr[AW-1:2]), .bus_rdata(buf_word),
    .eng_we(eb_we), .eng_widx(eb_widx), .eng_wdata(eb_wdata),
    .eng_ridx(eb_ridx), .eng_rdata(eb_rdata)
  );

  spi_eng_seq #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W), .DESEL_W(DESEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(eng_start),
    .out_len(out_len_q), .in_len(in_len_q), .desel_cyc(desel_q),
    .buf_ridx(eb_ridx), .buf_rdata(eb_rdata), .buf_we(eb_we), .buf_widx(eb_widx),
    .buf_wdata(eb_wdata), .busy(eng_busy), .stat(eng_stat),
    .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  always_comb begin
    reg_rdata = '0;
    if (buf_hit) reg_rdata = buf_word;
    else case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[CB_BUSY]  = eng_busy;
        reg_rdata[CB_READY] = ready;
        reg_rdata[CB_EN]    = ctrl_en;
        reg_rdata[CB_MIO]   = ctrl_mio;
      end
      OFS_OUTL: reg_rdata[LEN_W-1:0] = out_len_q;
      OFS_INL:  reg_rdata[LEN_W-1:0] = in_len_q;
      OFS_MISC: begin
        reg_rdata[DESEL_W-1:0] = desel_q;
        reg_rdata[9:8]         = latch_q;
        reg_rdata[26:25]       = fifo_q;
      end
      OFS_STAT: reg_rdata[3:0] = eng_stat;
      default: reg_rdata = '0;
    endcase
  end

  logic unused_bits;
  assign unused_bits = ^{reg_wdata, reg_addr[1:0]};

  AST_READY_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) eng_busy |-> ready); // R3
  AST_BAD_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (trig_acc && !lens_valid && !soft_rst) |=> (spi_cs_n && !eng_busy && ready)); // R7
  AST_START_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (eng_start && !soft_rst) |=> (!spi_cs_n && eng_busy)); // R3
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n) soft_rst |=> (spi_cs_n && !spi_sclk && !eng_busy && !ready)); // R11
endmodule

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;
  localparam logic [11:0] A_CTRL = 12'h500, A_OUTL = 12'h504, A_INL = 12'h508;
  localparam logic [11:0] A_MISC = 12'h538, A_STAT = 12'h550, A_BUF = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0, reg_wen = 1'b0, spi_miso = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic spi_cs_n, spi_sclk, spi_mosi;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  spi_cmd_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(int k);
    return 8'((k * 29 + 91) & 255);
  endfunction

  // behavioural reference: a cycle counter since acceptance and a byte image
  logic [7:0] m_buf [128];
  bit m_busy = 0;
  int m_cyc = 0, m_out = 0, m_in = 0, m_outr = 0, m_inr = 0, m_n = 0;

  always @(posedge clk) begin : model
    bit was_busy;
    int a;
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_outr = 0; m_inr = 0; m_n = 0;
    end else begin
      was_busy = m_busy;
      if (was_busy) begin
        m_cyc++;
        if (m_cyc == 16 * (m_out + m_in) + m_n + 1) begin
          for (int k = 0; k < m_in; k++) m_buf[m_out + k] = resp(k);
          m_busy = 0;
        end
      end
      if (reg_wen) begin
        if (reg_addr == A_OUTL) m_outr = int'(reg_wdata[7:0]);
        if (reg_addr == A_INL)  m_inr  = int'(reg_wdata[7:0]);
        if (reg_addr == A_MISC) begin
          m_n = int'(reg_wdata[4:0]);
          if (reg_wdata[28]) m_busy = 0;
        end
        if (reg_addr == A_CTRL && reg_wdata[3] && reg_wdata[2] && !was_busy &&
            m_outr != 0 && m_outr + m_inr <= 128) begin
          m_busy = 1; m_cyc = 0; m_out = m_outr; m_in = m_inr;
        end
        if (reg_addr >= A_BUF && reg_addr < A_BUF + 12'd128 && !was_busy) begin
          a = int'(reg_addr) - 2048;
          a = a - a % 4;
          for (int b = 0; b < 4; b++) m_buf[a + b] = reg_wdata[8*b +: 8];
        end
      end
    end
  end

  // per-cycle comparison of the pins, and the flash's MISO reply
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_cs, e_sclk, e_mosi;
      int b, bit_i;
      e_cs = !(m_busy && m_cyc < 16 * (m_out + m_in));
      e_sclk = e_cs ? 1'b0 : 1'(m_cyc % 2);
      chk("R6 cs_n per cycle", 32'(spi_cs_n), 32'(e_cs));
      chk("R4 sclk per cycle", 32'(spi_sclk), 32'(e_sclk));
      spi_miso = 1'b0;
      if (!e_cs) begin
        b = m_cyc / 16;
        bit_i = 7 - (m_cyc % 16) / 2;
        e_mosi = (b < m_out) ? m_buf[b][bit_i] : 1'b0;
        chk("R4 R5 mosi per cycle", 32'(spi_mosi), 32'(e_mosi));
        if (b >= m_out) spi_miso = resp(b - m_out)[bit_i];
      end
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cmp_buf(string req);
    logic [31:0] d;
    for (int w = 0; w < 32; w++) begin
      rd(A_BUF + 12'(w * 4), d);
      chk(req, d, {m_buf[4*w+3], m_buf[4*w+2], m_buf[4*w+1], m_buf[4*w]});
    end
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      rd(A_CTRL, d);
      if (!d[0]) break;
    end
  endtask

  task automatic run(int o, int i);
    wr(A_OUTL, 32'(o));
    wr(A_INL, 32'(i));
    wr(A_CTRL, 32'h8);
    wr(A_CTRL, 32'hC);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_n", 32'(spi_cs_n), 32'd1);
    chk("R1 sclk", 32'(spi_sclk), 32'd0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'd0);
    rd(A_STAT, d); chk("R1 status", d, 32'd0);
    rd(A_OUTL, d); chk("R1 outlen", d, 32'd0);
    rd(A_MISC, d); chk("R1 misc", d, 32'd0);

    // R2: fill the whole buffer and read it back
    for (int w = 0; w < 32; w++) wr(A_BUF + 12'(w * 4), 32'h1020_3040 ^ (32'(w) * 32'h0101_0107));
    cmp_buf("R2 buffer readback");
    wr(A_OUTL, 32'h1FF); rd(A_OUTL, d); chk("R2 outlen readback", d, 32'hFF);
    wr(A_INL, 32'h2C);   rd(A_INL, d);  chk("R2 inlen readback", d, 32'h2C);
    wr(A_MISC, (32'd2 << 25) | (32'd1 << 8) | 32'd10);
    rd(A_MISC, d); chk("R11 misc readback", d, (32'd2 << 25) | (32'd1 << 8) | 32'd10);

    // read command: 4 out, 4 in, deselect 10
    run(4, 4);
    rd(A_CTRL, d); chk("R3 busy and ready after trigger", d, 32'hB);
    chk("R3 cs_n low after trigger", 32'(spi_cs_n), 32'd0);
    rd(A_STAT, d); chk("R10 status output phase", d, 32'd1);
    repeat (69) @(negedge clk);
    rd(A_STAT, d); chk("R10 status input phase", d, 32'd2);
    repeat (62) @(negedge clk);
    rd(A_STAT, d); chk("R10 status deselect", d, 32'd3);
    repeat (7) @(negedge clk);
    rd(A_CTRL, d); chk("R6 busy held N cycles", d & 32'h1, 32'h1);
    @(negedge clk);
    rd(A_CTRL, d); chk("R6 busy clears at N+1", d & 32'h3, 32'h2);
    rd(A_STAT, d); chk("R10 status idle", d, 32'd0);
    cmp_buf("R5 input stored after output");

    // write-only command with no deselect time
    wr(A_MISC, 32'd2 << 25);
    run(9, 0);
    wait_idle();
    cmp_buf("R5 write-only leaves buffer");

    // exact capacity: 1 out, 127 in
    run(1, 127);
    wait_idle();
    cmp_buf("R5 full 128-byte transfer");

    // R7: invalid lengths
    run(0, 5);
    rd(A_CTRL, d); chk("R7 zero outlen ready only", d, 32'hA);
    repeat (40) @(negedge clk);
    chk("R7 cs_n stays high", 32'(spi_cs_n), 32'd1);
    run(100, 29);
    rd(A_CTRL, d); chk("R7 oversize ready only", d, 32'hA);
    repeat (40) @(negedge clk);
    cmp_buf("R7 buffer unchanged");

    // R9: ready clear and field readback
    wr(A_CTRL, 32'h0);  rd(A_CTRL, d); chk("R9 ready cleared", d, 32'h0);
    wr(A_CTRL, 32'h18); rd(A_CTRL, d); chk("R9 en and mio readback", d, 32'h18);

    // R8 and R12: retrigger and buffer write while busy
    wr(A_MISC, 32'd3);
    run(3, 2);
    wr(A_OUTL, 32'd50);
    wr(A_CTRL, 32'hC);
    wr(A_BUF, 32'hDEAD_BEEF);
    rd(A_CTRL, d); chk("R8 still busy after retrigger", d & 32'h1, 32'h1);
    wait_idle();
    cmp_buf("R8 R12 buffer after ignored writes");
    rd(A_OUTL, d); chk("R2 outlen written while busy", d, 32'd50);

    // R11: soft reset in the middle of the output phase
    run(4, 4);
    repeat (20) @(negedge clk);
    wr(A_MISC, (32'd1 << 28) | (32'd2 << 25) | (32'd1 << 8) | 32'd10);
    chk("R11 cs_n after soft reset", 32'(spi_cs_n), 32'd1);
    chk("R11 sclk after soft reset", 32'(spi_sclk), 32'd0);
    rd(A_CTRL, d); chk("R11 ctrl after soft reset", d, 32'd0);
    rd(A_STAT, d); chk("R11 status after soft reset", d, 32'd0);
    rd(A_MISC, d); chk("R11 misc fields kept, reset bit reads 0", d, (32'd2 << 25) | (32'd1 << 8) | 32'd10);
    cmp_buf("R11 buffer after abort");

    // engine usable after the abort
    run(2, 1);
    wait_idle();
    cmp_buf("R5 transfer after soft reset");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule